// File: doc/BRIEF.md
# Transmit Queue with Bit Serializer

The block is the send half of a serial bus controller. A host pushes 18-bit words into a 64-deep queue through a valid/ready write port. The queue is a storage array with separate write and read address counters and an occupancy count. When the serializer is idle and the queue holds data, the oldest word is copied into a parallel-load shift register. That register then moves one bit onto the line, most significant bit first, on each cycle where the shift enable is high.

A diagnostic mode gives direct access to the storage. While `diag_mode` is high, an address taken from pins replaces both counters. A host write lands at that address. A `diag_load` request copies that location into the serializer, and the word is then observed only on the serial line. The counters and the occupancy count stay frozen in this mode.

Back-pressure on the write port works as follows. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. In normal mode `wr_ready` is low while the queue is full. The host must then hold its word until `wr_ready` returns. A word offered against a low `wr_ready` is not stored. The serial side has no back-pressure of its own: `shift_en` only paces the bits.

Top module: `txq_serializer`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, `wr_ready`=1, `ser_busy`=0, `ser_bit`=0 and `word_done`=0.
- R2: The queue holds up to 64 words. `q_full` is high exactly when 64 words are held and `q_empty` exactly when none are. In normal mode `wr_ready` equals the inverse of `q_full`.
- R3: In normal mode, a word offered while the queue is full is not stored and changes no state.
- R4: Words leave through the serializer in the order in which they were accepted.
- R5: A loaded word appears on `ser_bit` starting with bit 17. The line advances by one bit on each cycle in which `shift_en` is high and `ser_busy` is high. It holds its value while `shift_en` is low.
- R6: On the clock edge of the 18th shift, `ser_busy` falls and `word_done` rises for exactly one cycle. If data is waiting, the next word is loaded on the following edge.
- R7: A serializer load with the queue empty does not happen: `ser_busy` stays 0 and `ser_bit` stays 0.
- R8: The write and read counters wrap modulo 64, so the queue keeps its order across more than 64 words in total.
- R9: In diagnostic mode a write is always accepted (`wr_ready`=1) and goes to `diag_addr`. The occupancy count, both counters, `q_empty` and `q_full` stay unchanged.
- R10: In diagnostic mode, `diag_load` with the serializer idle loads the word at `diag_addr` into the serializer without changing the counters or the count.
- R11: In normal mode, `diag_addr` and `diag_load` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host offers a word |
| wr_ready | output | 1 | Block accepts a word this cycle |
| wr_data | input | 18 | Word from host |
| shift_en | input | 1 | Advance serial line by one bit |
| ser_bit | output | 1 | Serial line output |
| ser_busy | output | 1 | Serializer holds a word in flight |
| word_done | output | 1 | One-cycle pulse after the last bit of a word |
| q_empty | output | 1 | Queue holds no word |
| q_full | output | 1 | Queue holds 64 words |
| diag_mode | input | 1 | Diagnostic addressing enable |
| diag_addr | input | 6 | Storage address used in diagnostic mode |
| diag_load | input | 1 | Diagnostic request to load the serializer |

## Verification
The assertions assume that the mode pin changes only between whole operations and never changes inside a reset. They also assume that the write data is stable whenever it is offered. The bench changes `diag_mode` only while the serializer is idle and no write is offered, and it drives all inputs just after a clock edge. Apart from that, the stimulus may offer writes against a full queue and may raise `diag_load` and `diag_addr` in normal mode. These are cases the design must tolerate, so the stimulus covers them.

// File: rtl/txq_pkg.sv
package txq_pkg;
  parameter int unsigned TXQ_WORD_W = 18;
  parameter int unsigned TXQ_DEPTH  = 64;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          ser_idle,
  input  logic          diag_mode,
  input  logic [AW-1:0] diag_addr,
  input  logic          diag_load,
  output logic          st_we,
  output logic [AW-1:0] st_waddr,
  output logic [AW-1:0] st_raddr,
  output logic          ser_load,
  output logic          q_empty,
  output logic          q_full
);
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  logic          push, pop;

  assign q_empty  = (occ == '0);
  assign q_full   = (occ == CW'(DEPTH));
  assign wr_ready = diag_mode | ~q_full;
  assign st_we    = wr_valid & wr_ready;
  assign st_waddr = diag_mode ? diag_addr : wptr;
  assign st_raddr = diag_mode ? diag_addr : rptr;
  assign ser_load = ser_idle & (diag_mode ? diag_load : ~q_empty);
  assign push     = st_we & ~diag_mode;
  assign pop      = ser_load & ~diag_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));
  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !diag_mode && !ser_idle) |=> q_full);
  // R7
  empty_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !diag_mode) |-> !ser_load);
  // R9
  diag_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_mode |=> (occ == $past(occ)) && (wptr == $past(wptr)) && (rptr == $past(rptr)));
endmodule

// File: rtl/txq_piso.sv
module txq_piso #(
  parameter int unsigned WORD_W = 18,
  localparam int unsigned BW    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              shift_en,
  output logic              idle,
  output logic              ser_bit,
  output logic              word_done
);
  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bcnt;
  logic              busy;
  logic              last;

  assign last    = (bcnt == BW'(WORD_W - 1));
  assign idle    = ~busy;
  assign ser_bit = shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bcnt      <= '0;
      busy      <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (load) begin
        shreg <= din;
        bcnt  <= '0;
        busy  <= 1'b1;
      end else if (busy && shift_en) begin
        shreg <= {shreg[WORD_W-2:0], 1'b0};
        if (last) begin
          bcnt      <= '0;
          busy      <= 1'b0;
          word_done <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  // R6
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !busy);
  // R5
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_en) |=> $stable(shreg));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_bit);
endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
  import txq_pkg::*;
#(
  parameter int unsigned WORD_W = TXQ_WORD_W,
  parameter int unsigned DEPTH  = TXQ_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              shift_en,
  output logic              ser_bit,
  output logic              ser_busy,
  output logic              word_done,
  output logic              q_empty,
  output logic              q_full,
  input  logic              diag_mode,
  input  logic [AW-1:0]     diag_addr,
  input  logic              diag_load
);
  logic              st_we, ser_load, ser_idle;
  logic [AW-1:0]     st_waddr, st_raddr;
  logic [WORD_W-1:0] st_rdata;

  txq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .ser_idle(ser_idle), .diag_mode(diag_mode), .diag_addr(diag_addr),
    .diag_load(diag_load), .st_we(st_we), .st_waddr(st_waddr),
    .st_raddr(st_raddr), .ser_load(ser_load), .q_empty(q_empty), .q_full(q_full)
  );

  txq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(wr_data),
    .raddr(st_raddr), .rdata(st_rdata)
  );

  txq_piso #(.WORD_W(WORD_W)) piso_i (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .din(st_rdata),
    .shift_en(shift_en), .idle(ser_idle), .ser_bit(ser_bit), .word_done(word_done)
  );

  assign ser_busy = ~ser_idle;

  // R2
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_mode |-> (wr_ready == !q_full));
endmodule

// File: tb/txq_serializer_tb.sv
module txq_serializer_tb_top;
  localparam int CLK_NS = 10;
  localparam int W = 18;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, shift_en = 1'b0, diag_mode = 1'b0, diag_load = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [5:0] diag_addr = '0;
  logic wr_ready, ser_bit, ser_busy, word_done, q_empty, q_full;

  txq_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .shift_en(shift_en), .ser_bit(ser_bit),
    .ser_busy(ser_busy), .word_done(word_done), .q_empty(q_empty),
    .q_full(q_full), .diag_mode(diag_mode), .diag_addr(diag_addr),
    .diag_load(diag_load)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  string req = "R1";

  // behavioural reference
  int mem [D];
  int wp = 0, rp = 0, cnt = 0;
  int word = 0, left = 0;
  bit busy = 0, done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp = 0; rp = 0; cnt = 0; word = 0; left = 0; busy = 0; done = 0;
    end else begin
      automatic bit acc = wr_valid && (diag_mode || cnt < D);
      automatic bit ld  = !busy && (diag_mode ? diag_load : cnt > 0);
      automatic bit sh  = busy && shift_en;
      automatic int ra  = diag_mode ? int'(diag_addr) : rp;
      automatic int rv  = mem[ra];
      done = sh && left == 1;
      if (acc) begin
        mem[diag_mode ? int'(diag_addr) : wp] = int'(wr_data);
        if (!diag_mode) begin wp = (wp + 1) % D; cnt++; end
      end
      if (ld) begin
        word = rv; left = W; busy = 1;
        if (!diag_mode) begin rp = (rp + 1) % D; cnt--; end
      end else if (sh) begin
        word = (word << 1) & ((1 << W) - 1); left--;
        if (left == 0) busy = 0;
      end
    end
  end

  task automatic chk(input string sig, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("wr_ready", int'(wr_ready), int'(diag_mode || cnt < D));
    chk("q_empty", int'(q_empty), int'(cnt == 0));
    chk("q_full", int'(q_full), int'(cnt == D));
    chk("ser_busy", int'(ser_busy), int'(busy));
    chk("ser_bit", int'(ser_bit), (word >> (W-1)) & 1);
    chk("word_done", int'(word_done), int'(done));
  end

  task automatic go(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    go(3); rst_n = 1'b1; #1;
    // R1 reset state
    req = "R1";
    chk("rst_empty", int'(q_empty), 1); chk("rst_full", int'(q_full), 0);
    chk("rst_ready", int'(wr_ready), 1); chk("rst_busy", int'(ser_busy), 0);
    chk("rst_bit", int'(ser_bit), 0); chk("rst_done", int'(word_done), 0);
    // R7 shifting with nothing queued
    req = "R7"; shift_en = 1'b1; go(10);
    // R4 R5 R6 order and bit pacing with irregular shift enable
    req = "R4_R5_R6";
    for (int i = 0; i < 6; i++) begin
      wr_valid = 1'b1; wr_data = W'($urandom); go(1);
      wr_valid = 1'b0; shift_en = 1'($urandom); go(1);
    end
    for (int i = 0; i < 300; i++) begin shift_en = ($urandom % 3) != 0; go(1); end
    // R2 R3 fill beyond capacity with shifting stopped
    req = "R2_R3"; shift_en = 1'b0; go(30);
    for (int i = 0; i < 70; i++) begin wr_valid = 1'b1; wr_data = W'($urandom); go(1); end
    wr_valid = 1'b0; go(3);
    // R8 drain with sporadic writes, wraps the counters
    req = "R8"; shift_en = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      wr_valid = ($urandom % 20) == 0; wr_data = W'($urandom); go(1);
    end
    wr_valid = 1'b0; go(300);
    // R9 diagnostic writes
    req = "R9"; shift_en = 1'b0; diag_mode = 1'b1;
    diag_addr = 6'd63; wr_valid = 1'b1; wr_data = 18'h2A5C3; go(1);
    diag_addr = 6'd5;  wr_data = 18'h3FFFF; go(1);
    diag_addr = 6'd0;  wr_data = 18'h00001; go(1);
    wr_valid = 1'b0; go(2);
    // R10 diagnostic reads through the serializer
    req = "R10";
    diag_addr = 6'd63; diag_load = 1'b1; go(1); diag_load = 1'b0;
    shift_en = 1'b1; go(25);
    diag_addr = 6'd0; diag_load = 1'b1; go(1); diag_load = 1'b0; go(25);
    diag_addr = 6'd5; diag_load = 1'b1; go(1); diag_load = 1'b0; go(25);
    diag_mode = 1'b0; go(2);
    // R11 diagnostic pins active in normal mode
    req = "R11"; diag_load = 1'b1;
    for (int i = 0; i < 200; i++) begin
      diag_addr = 6'($urandom); wr_valid = ($urandom % 8) == 0; wr_data = W'($urandom);
      shift_en = ($urandom % 4) != 0; go(1);
    end
    wr_valid = 1'b0; diag_load = 1'b0; shift_en = 1'b1; go(200);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule